// File: doc/BRIEF.md
# Pin Group Level-Change Interrupt Detector

This block watches a small group of input pins and raises a single shared interrupt whenever the combined "active" state of the enabled pins flips. Each pin has a polarity bit that sets its resting level. Low means the pin rests low and a high level counts as active. High means the pin rests high and a low level counts as active. The enabled pins, after this polarity correction, are OR-combined into one level. That level is compared only at a slow sampling strobe, which is the falling edge of one of two time-base taps chosen by a rate bit.

When every enabled pin rests and any one of them becomes active, the block requests an interrupt. When one or more are active, it requests again only once all of them have gone back to rest. A request is a one-cycle pulse that also sets a sticky flag. The flag, gated by a master enable, drives the line to the interrupt priority encoder, and the fixed vector address is presented as a constant. No per-pin cause is kept, so software reads the pins to learn which one moved.

Top module: `pin_change_irq`

## Requirements
- R1: After reset the request pulse, sticky flag and encoder line are all 0.
- R2: The combined level is sampled only when the selected tap falls: rate_sel=0 selects tap_slow and rate_sel=1 selects tap_fast. A falling edge on the tap that is not selected produces no request.
- R3: Pin i counts as active when pin_in[i] differs from pin_mode[i] (mode 0: high is active; mode 1: low is active), and only while pin_en[i]=1. A pin with pin_en[i]=0 never causes a request.
- R4: If no enabled pin was active at the previous sample, a request is made at the first sample where at least one enabled pin is active.
- R5: If an enabled pin was active at the previous sample, a request is made only at the first sample where all enabled pins rest. A change among active pins that leaves at least one active makes no request.
- R6: A request is a single-cycle irq_pulse that rises on the third rising clock edge after the tap input falls. Two requests never occur on consecutive cycles.
- R7: irq_flag is set together with every request and stays set until flag_clr is seen. If a clear and a request fall on the same cycle, the flag ends up set.
- R8: irq_line equals irq_flag when irq_en=1 and is 0 when irq_en=0.
- R9: After any change to pin_en or pin_mode, the next sample updates the stored combined level and makes no request.
- R10: irq_vector is the constant 16'h0016.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | NPIN | Raw pin levels |
| tap_slow | input | 1 | Slow time-base tap (128 Hz) |
| tap_fast | input | 1 | Fast time-base tap (4 kHz) |
| rate_sel | input | 1 | 0 selects tap_slow, 1 selects tap_fast |
| pin_en | input | NPIN | Per-pin participation enable |
| pin_mode | input | NPIN | Per-pin resting level (1 = rests high) |
| irq_en | input | 1 | Master enable toward the encoder |
| flag_clr | input | 1 | Clears the sticky flag |
| irq_pulse | output | 1 | One-cycle request pulse |
| irq_flag | output | 1 | Sticky request flag |
| irq_line | output | 1 | Gated request to the priority encoder |
| irq_vector | output | 16 | Vector address of this source |

## Verification
A tap's falling edge passes two synchronizer stages and then forms the strobe. Pulse and flag therefore change on the third rising edge after the fall, and the bench samples them at the falling edge right after that one. Pins and configuration are set at least four cycles before a tap falls, so the synchronized pin values are settled when the strobe arrives. The same-cycle clear is driven in the strobe cycle itself, the second cycle after the fall. irq_line is combinational from the flag and is checked in the same sample. A standalone clear is seen on the flag one cycle later.

// File: rtl/pin_change_irq.sv
module pin_change_irq #(
  parameter int          NPIN   = 4,
  parameter int          SYNC   = 2,
  parameter logic [15:0] VECTOR = 16'h0016
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_in,
  input  logic            tap_slow,
  input  logic            tap_fast,
  input  logic            rate_sel,
  input  logic [NPIN-1:0] pin_en,
  input  logic [NPIN-1:0] pin_mode,
  input  logic            irq_en,
  input  logic            flag_clr,
  output logic            irq_pulse,
  output logic            irq_flag,
  output logic            irq_line,
  output logic [15:0]     irq_vector
);
  localparam int CFGW = 2 * NPIN;

  logic [NPIN-1:0] pin_sy [SYNC];
  logic [1:0]      tap_sy [SYNC];
  logic            tap_prev;
  logic            held;
  logic            dirty;
  logic [CFGW-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) begin
        pin_sy[i] <= '0;
        tap_sy[i] <= '0;
      end
    end else begin
      pin_sy[0] <= pin_in;
      tap_sy[0] <= {tap_fast, tap_slow};
      for (int i = 1; i < SYNC; i++) begin
        pin_sy[i] <= pin_sy[i-1];
        tap_sy[i] <= tap_sy[i-1];
      end
    end
  end

  wire tap_now = rate_sel ? tap_sy[SYNC-1][1] : tap_sy[SYNC-1][0];
  wire strobe  = tap_prev & ~tap_now;
  wire level   = |((pin_sy[SYNC-1] ^ pin_mode) & pin_en);
  wire cfg_chg = {pin_en, pin_mode} != cfg_q;
  wire stale   = dirty | cfg_chg;
  wire det     = strobe & ~stale & (level != held);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_prev  <= 1'b0;
      held      <= 1'b0;
      dirty     <= 1'b0;
      cfg_q     <= '0;
      irq_pulse <= 1'b0;
      irq_flag  <= 1'b0;
    end else begin
      tap_prev  <= tap_now;
      cfg_q     <= {pin_en, pin_mode};
      dirty     <= strobe ? 1'b0 : stale;
      if (strobe) held <= level;
      irq_pulse <= det;
      if (det)           irq_flag <= 1'b1;
      else if (flag_clr) irq_flag <= 1'b0;
    end
  end

  assign irq_line   = irq_flag & irq_en;
  assign irq_vector = VECTOR;

  assert_pulse_needs_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(strobe));
  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
  assert_pulse_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> irq_flag);
  assert_flag_fall_by_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_flag) |-> $past(flag_clr));
  assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (det && flag_clr) |=> irq_flag);
  assert_no_req_after_cfg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && stale) |=> !irq_pulse);
  assert_line_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq_line);
endmodule

// File: tb/pin_change_irq_test.sv
`timescale 1ns/1ps
module pin_change_irq_test;
  logic clk = 0, rst_n = 0;
  logic [3:0] pin_in = 0, pin_en = 0, pin_mode = 0;
  logic tap_slow = 0, tap_fast = 0, rate_sel = 0, irq_en = 0, flag_clr = 0;
  logic irq_pulse, irq_flag, irq_line;
  logic [15:0] irq_vector;
  int checks = 0, errors = 0;
  bit m_held = 0, m_dirty = 0, m_flag = 0;

  always #2 clk = ~clk;

  pin_change_irq uut (.clk, .rst_n, .pin_in, .tap_slow, .tap_fast, .rate_sel,
    .pin_en, .pin_mode, .irq_en, .flag_clr, .irq_pulse, .irq_flag, .irq_line, .irq_vector);

  function automatic bit comb(logic [3:0] p, logic [3:0] e, logic [3:0] m);
    return |((p ^ m) & e);
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_cfg(logic [3:0] e, logic [3:0] m);
    @(negedge clk);
    if (e != pin_en || m != pin_mode) m_dirty = 1;
    pin_en = e; pin_mode = m;
  endtask

  task automatic sample(bit sel_tap, bit clr, string req);
    bit det, lv;
    @(negedge clk);
    if (sel_tap ^ rate_sel) tap_slow = 1; else tap_fast = 1;
    repeat (4) @(negedge clk);
    tap_slow = 0; tap_fast = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); flag_clr = clr;
    @(posedge clk);
    @(negedge clk); flag_clr = 0;
    if (!sel_tap) begin
      det = 0;
    end else begin
      lv = comb(pin_in, pin_en, pin_mode);
      det = !m_dirty && (lv != m_held);
      m_held = lv; m_dirty = 0;
    end
    if (det) m_flag = 1; else if (clr) m_flag = 0;
    chk({req, " pulse"}, irq_pulse, det);
    chk({req, " flag"}, irq_flag, m_flag);
    chk("R8 line", irq_line, m_flag & irq_en);
    @(negedge clk);
    chk("R6 pulse width", irq_pulse, 0);
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0; m_flag = 0;
    chk("R7 clear", irq_flag, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk("R1 pulse", irq_pulse, 0);
    chk("R1 flag", irq_flag, 0);
    chk("R1 line", irq_line, 0);
    chk("R10 vector", irq_vector, 16'h0016);
    rst_n = 1;
    irq_en = 1;
    // R9: enabling with pins active -> no request
    pin_in = 4'b1111;
    set_cfg(4'b1111, 4'b0000);
    sample(1, 0, "R9 cfg change");
    // R5 walk
    pin_in = 4'b0000; sample(1, 0, "R5 all idle");
    clear_flag();
    pin_in = 4'b0001; sample(1, 0, "R4 one active");
    pin_in = 4'b0011; sample(1, 0, "R5 more active");
    pin_in = 4'b0010; sample(1, 0, "R5 still one active");
    pin_in = 4'b0000; sample(1, 0, "R5 all idle");
    // R2: unselected tap ignored, then fast rate
    pin_in = 4'b0100; sample(0, 0, "R2 other tap");
    rate_sel = 1; sample(0, 0, "R2 other tap fast");
    sample(1, 0, "R2 fast tap");
    // R7: set wins over clear
    pin_in = 4'b0000; sample(1, 1, "R7 set beats clear");
    // R3: low-active mode and disabled pin
    set_cfg(4'b0111, 4'b1111);
    pin_in = 4'b0111; sample(1, 0, "R9 mode change");
    pin_in = 4'b1111; sample(1, 0, "R3 disabled pin");
    pin_in = 4'b1101; sample(1, 0, "R3 low active");
    // R8 masked
    irq_en = 0; sample(1, 1, "R8 masked");
    irq_en = 1;
    for (int n = 0; n < 200; n++) begin
      if ($urandom % 6 == 0) set_cfg(4'($urandom), 4'($urandom));
      if ($urandom % 8 == 0) rate_sel = $urandom % 2;
      if ($urandom % 5 == 0) irq_en = $urandom % 2;
      if ($urandom % 7 == 0) clear_flag();
      pin_in = 4'($urandom);
      sample(($urandom % 8) != 0, ($urandom % 6) == 0, "R4 R5 random");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule